// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, once per cycle, which hardware thread of a multithreaded core may use the instruction fetch path. It reads a per-thread fetch status code, a mask of threads that are currently active, and two per-thread occupancy counts (issue queue and load/store queue). It returns a thread index with a valid flag. The index and flag are combinational in the inputs and in one internal register, so the fetch logic can use the answer in the same cycle.

A two-bit policy input picks the arbitration rule. Code 0 is fixed-thread. Code 1 is rotating priority. Code 2 is least issue-queue occupancy. Code 3 is least load/store-queue occupancy. The rotating policy keeps an ordered list of thread indices. A grant strobe tells the block that its choice was used; the chosen thread then moves to the back of the list. A thread-count input states how many threads are configured. With a count of one, the policy input does not matter.

Top module: `fetch_thread_sel`

## Requirements
- R1: Thread t is eligible when its active bit is set, t is below the configured thread count, and its 3-bit status is 0 (running), 1 (idle) or 4 (cache fill complete). Codes 2, 3, 5, 6 and 7 (squashing, blocked, waiting on response, waiting on retry, trap pending) make it ineligible. Status of thread t sits at bits [3t+2:3t].
- R2: Under policy 1 with more than one thread configured, the output is the eligible thread nearest the head of the priority list.
- R3: On a clock edge where policy 1 is in force with more than one thread configured, the selection is valid and grant is high, the selected thread moves to the tail of the list. Entries behind it each move up one place, and entries ahead of it keep their places. At any other edge the list is unchanged.
- R4: Reset puts the priority list in ascending order, thread 0 at the head.
- R5: Under policy 2 the output is the eligible thread with the smallest issue-queue count. Under policy 3 it is the eligible thread with the smallest load/store-queue count. Ties go to the lowest index. Count t is at bits [4t+3:4t] of its bus.
- R6: When no thread qualifies, the valid flag is low and the index output is 0.
- R7: Under policy 0 with more than one thread configured, the output is thread 0 with valid high, whatever the status and active inputs are.
- R8: With a thread count of one, the output is the lowest-index active thread, valid only if its status is 0, 1 or 4. The priority list does not move.
- R9: With more than one thread configured, threads at or above the configured count are never selected, even if they are active and fetchable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Arbitration rule: 0 fixed, 1 rotate, 2 issue-queue, 3 load/store-queue |
| thr_cnt_i | input | 3 | Number of configured threads (1 to 4) |
| status_i | input | 12 | Per-thread 3-bit fetch status codes |
| active_i | input | 4 | Per-thread active mask |
| iq_cnt_i | input | 16 | Per-thread 4-bit issue-queue occupancy |
| lsq_cnt_i | input | 16 | Per-thread 4-bit load/store-queue occupancy |
| grant_i | input | 1 | Selection consumed; lets the rotating list advance |
| sel_tid_o | output | 2 | Selected thread index |
| sel_valid_o | output | 1 | A thread was selected |

## Verification
The assertions assume that the thread count stays between 1 and 4 while the block is out of reset. They also assume that grant is only meaningful in a cycle whose outputs were observed. No assumption is made about the status codes, since all eight values are legal. The stimulus drives every input at the falling clock edge and uses thread counts of 1, 2 and 4 only. It sends grant with an invalid selection and with non-rotating policies, so that the rule saying the list stays unchanged is exercised.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

  localparam logic [2:0] ST_RUN     = 3'd0;
  localparam logic [2:0] ST_IDLE    = 3'd1;
  localparam logic [2:0] ST_SQUASH  = 3'd2;
  localparam logic [2:0] ST_BLOCKED = 3'd3;
  localparam logic [2:0] ST_FILLED  = 3'd4;
  localparam logic [2:0] ST_WAITRSP = 3'd5;
  localparam logic [2:0] ST_WAITRTY = 3'd6;
  localparam logic [2:0] ST_TRAP    = 3'd7;

  localparam logic [1:0] POL_FIXED  = 2'd0;
  localparam logic [1:0] POL_ROTATE = 2'd1;
  localparam logic [1:0] POL_IQ     = 2'd2;
  localparam logic [1:0] POL_LSQ    = 2'd3;

  // A thread may fetch only from these status codes.
  function automatic logic can_fetch(input logic [2:0] st);
    return (st == ST_RUN) || (st == ST_IDLE) || (st == ST_FILLED);
  endfunction

endpackage

// File: rtl/fsel_elig.sv
module fsel_elig
  import fsel_pkg::*;
#(
  parameter int NT    = 4,
  parameter int CNT_W = 3
) (
  input  logic [NT*3-1:0]  status_i,
  input  logic [NT-1:0]    active_i,
  input  logic [CNT_W-1:0] thr_cnt_i,
  output logic [NT-1:0]    ready_o,
  output logic [NT-1:0]    elig_o
);
  for (genvar t = 0; t < NT; t++) begin : g_thr
    assign ready_o[t] = active_i[t] && can_fetch(status_i[3*t +: 3]);
    assign elig_o[t]  = ready_o[t] && (CNT_W'(t) < thr_cnt_i);
  end
endmodule

// File: rtl/fsel_min_pick.sv
module fsel_min_pick #(
  parameter int NT = 4,
  parameter int CW = 4,
  parameter int IW = 2
) (
  input  logic [NT-1:0]    elig_i,
  input  logic [NT*CW-1:0] cnt_i,
  output logic [IW-1:0]    tid_o,
  output logic             valid_o
);
  logic [CW-1:0] best_cnt;
  logic [NT-1:0] not_below;

  always_comb begin
    valid_o  = 1'b0;
    tid_o    = '0;
    best_cnt = '0;
    for (int t = 0; t < NT; t++) begin
      // strict compare keeps the lowest index on a tie
      if (elig_i[t] && (!valid_o || cnt_i[CW*t +: CW] < best_cnt)) begin
        valid_o  = 1'b1;
        tid_o    = IW'(t);
        best_cnt = cnt_i[CW*t +: CW];
      end
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_cmp
    assign not_below[t] = !elig_i[t] || (cnt_i[CW*t +: CW] >= best_cnt);
  end

  // R5
  always_comb begin
    min_count_chk: assert (!valid_o || (&not_below && elig_i[tid_o]));
  end
endmodule

// File: rtl/fsel_rr_order.sv
module fsel_rr_order #(
  parameter int NT = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] elig_i,
  input  logic          advance_i,
  output logic [IW-1:0] tid_o,
  output logic          valid_o
);
  logic [NT*IW-1:0] order_q, order_d;
  logic [IW-1:0]    hit_pos;
  logic [NT-1:0]    seen;

  // scan from the head for the first eligible entry
  always_comb begin
    valid_o = 1'b0;
    tid_o   = '0;
    hit_pos = '0;
    for (int p = 0; p < NT; p++) begin
      if (!valid_o && elig_i[order_q[IW*p +: IW]]) begin
        valid_o = 1'b1;
        tid_o   = order_q[IW*p +: IW];
        hit_pos = IW'(p);
      end
    end
  end

  // winner goes to the tail, entries behind it shift forward
  always_comb begin
    order_d = order_q;
    for (int p = 0; p < NT - 1; p++) begin
      if (IW'(p) >= hit_pos) order_d[IW*p +: IW] = order_q[IW*(p+1) +: IW];
    end
    order_d[IW*(NT-1) +: IW] = tid_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NT; p++) order_q[IW*p +: IW] <= IW'(p);
    end else if (advance_i && valid_o) begin
      order_q <= order_d;
    end
  end

  always_comb begin
    seen = '0;
    for (int p = 0; p < NT; p++) seen[order_q[IW*p +: IW]] = 1'b1;
  end

  // R3
  perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == NT);
  // R3
  tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && valid_o) |=> order_q[IW*(NT-1) +: IW] == $past(tid_o));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance_i && valid_o) |=> $stable(order_q));
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fsel_pkg::*;
#(
  parameter int NT    = 4,
  parameter int CW    = 4,
  localparam int IW    = (NT > 1) ? $clog2(NT) : 1,
  localparam int CNT_W = $clog2(NT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy_i,
  input  logic [CNT_W-1:0] thr_cnt_i,
  input  logic [NT*3-1:0]  status_i,
  input  logic [NT-1:0]    active_i,
  input  logic [NT*CW-1:0] iq_cnt_i,
  input  logic [NT*CW-1:0] lsq_cnt_i,
  input  logic             grant_i,
  output logic [IW-1:0]    sel_tid_o,
  output logic             sel_valid_o
);
  logic [NT-1:0] ready, elig;
  logic          multi, fixed_mode, rr_advance;
  logic [IW-1:0] rr_tid, iq_tid, lsq_tid, first_tid;
  logic          rr_valid, iq_valid, lsq_valid, first_any;

  assign multi      = thr_cnt_i > CNT_W'(1);
  assign fixed_mode = multi && (policy_i == POL_FIXED);
  assign rr_advance = grant_i && multi && (policy_i == POL_ROTATE);

  fsel_elig #(.NT(NT), .CNT_W(CNT_W)) i_elig (
    .status_i (status_i),
    .active_i (active_i),
    .thr_cnt_i(thr_cnt_i),
    .ready_o  (ready),
    .elig_o   (elig)
  );

  fsel_rr_order #(.NT(NT), .IW(IW)) i_rr (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig_i   (elig),
    .advance_i(rr_advance),
    .tid_o    (rr_tid),
    .valid_o  (rr_valid)
  );

  fsel_min_pick #(.NT(NT), .CW(CW), .IW(IW)) i_iq (
    .elig_i (elig),
    .cnt_i  (iq_cnt_i),
    .tid_o  (iq_tid),
    .valid_o(iq_valid)
  );

  fsel_min_pick #(.NT(NT), .CW(CW), .IW(IW)) i_lsq (
    .elig_i (elig),
    .cnt_i  (lsq_cnt_i),
    .tid_o  (lsq_tid),
    .valid_o(lsq_valid)
  );

  // lowest-index active thread for the single-thread configuration
  always_comb begin
    first_any = 1'b0;
    first_tid = '0;
    for (int t = NT - 1; t >= 0; t--) begin
      if (active_i[t]) begin
        first_any = 1'b1;
        first_tid = IW'(t);
      end
    end
  end

  always_comb begin
    sel_valid_o = 1'b0;
    sel_tid_o   = '0;
    if (!multi) begin
      sel_valid_o = first_any && ready[first_tid];
      sel_tid_o   = sel_valid_o ? first_tid : '0;
    end else begin
      unique case (policy_i)
        POL_FIXED:  begin sel_valid_o = 1'b1;      sel_tid_o = '0;      end
        POL_ROTATE: begin sel_valid_o = rr_valid;  sel_tid_o = rr_tid;  end
        POL_IQ:     begin sel_valid_o = iq_valid;  sel_tid_o = iq_tid;  end
        default:    begin sel_valid_o = lsq_valid; sel_tid_o = lsq_tid; end
      endcase
    end
  end

  // R1
  elig_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_o && multi && !fixed_mode) |-> elig[sel_tid_o]);
  // R6
  none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (multi && !fixed_mode && !(|elig)) |-> (!sel_valid_o && sel_tid_o == '0));
  // R7
  fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_mode |-> (sel_valid_o && sel_tid_o == '0));
  // R8
  one_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!multi && sel_valid_o) |-> (active_i[sel_tid_o] && ready[sel_tid_o]));
endmodule

// File: tb/test_fetch_thread_sel.sv
module test_fetch_thread_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 22;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  pol;
    logic [2:0]  cnt;
    logic [11:0] st;
    logic [3:0]  act;
    logic [15:0] iq;
    logic [15:0] lsq;
    logic        gnt;
    logic        ev;
    logic [1:0]  et;
  } vec_t;

  // rotating list after reset is 0,1,2,3; comments give the list after each row
  localparam vec_t TBL [NROWS] = '{
    '{4'd4, 2'd1, 3'd4, 12'h000, 4'hF, 16'h0, 16'h0, 1'b1, 1'b1, 2'd0}, // R4 R2 -> 1230
    '{4'd3, 2'd1, 3'd4, 12'h000, 4'hF, 16'h0, 16'h0, 1'b1, 1'b1, 2'd1}, // R3 -> 2301
    '{4'd2, 2'd1, 3'd4, 12'h0C0, 4'hF, 16'h0, 16'h0, 1'b1, 1'b1, 2'd3}, // R2 t2 blocked -> 2013
    '{4'd3, 2'd1, 3'd4, 12'h000, 4'hF, 16'h0, 16'h0, 1'b0, 1'b1, 2'd2}, // R3 no grant
    '{4'd1, 2'd1, 3'd4, 12'h000, 4'hB, 16'h0, 16'h0, 1'b1, 1'b1, 2'd0}, // R1 t2 inactive -> 2130
    '{4'd6, 2'd1, 3'd4, 12'h6DB, 4'hF, 16'h0, 16'h0, 1'b1, 1'b0, 2'd0}, // R6 all blocked
    '{4'd1, 2'd1, 3'd4, 12'h040, 4'hF, 16'h0, 16'h0, 1'b1, 1'b1, 2'd2}, // R1 idle ok -> 1302
    '{4'd1, 2'd1, 3'd4, 12'h020, 4'hF, 16'h0, 16'h0, 1'b1, 1'b1, 2'd1}, // R1 fill done -> 3021
    '{4'd1, 2'd1, 3'd4, 12'hA00, 4'hF, 16'h0, 16'h0, 1'b0, 1'b1, 2'd0}, // R1 waiting response
    '{4'd5, 2'd2, 3'd4, 12'h000, 4'hF, 16'h5272, 16'h0, 1'b1, 1'b1, 2'd0}, // R5 tie
    '{4'd5, 2'd2, 3'd4, 12'h003, 4'hF, 16'h5272, 16'h0, 1'b0, 1'b1, 2'd2}, // R5
    '{4'd5, 2'd3, 3'd4, 12'h000, 4'hF, 16'h0, 16'h1389, 1'b0, 1'b1, 2'd3}, // R5 lsq
    '{4'd5, 2'd3, 3'd4, 12'h000, 4'h7, 16'h0, 16'h1389, 1'b0, 1'b1, 2'd2}, // R5
    '{4'd6, 2'd2, 3'd4, 12'h6DB, 4'hF, 16'h0, 16'h0, 1'b0, 1'b0, 2'd0}, // R6
    '{4'd7, 2'd0, 3'd4, 12'h6DB, 4'h0, 16'h0, 16'h0, 1'b0, 1'b1, 2'd0}, // R7
    '{4'd8, 2'd1, 3'd1, 12'h000, 4'h6, 16'h0, 16'h0, 1'b1, 1'b1, 2'd1}, // R8 no rotate
    '{4'd8, 2'd1, 3'd1, 12'h018, 4'h2, 16'h0, 16'h0, 1'b0, 1'b0, 2'd0}, // R8 not fetchable
    '{4'd8, 2'd1, 3'd4, 12'h000, 4'hF, 16'h0, 16'h0, 1'b1, 1'b1, 2'd3}, // R8 list held -> 0213
    '{4'd9, 2'd1, 3'd2, 12'h000, 4'hF, 16'h0, 16'h0, 1'b1, 1'b1, 2'd0}, // R9 -> 2130
    '{4'd9, 2'd1, 3'd2, 12'h000, 4'hF, 16'h0, 16'h0, 1'b0, 1'b1, 2'd1}, // R9 t2 excluded
    '{4'd1, 2'd2, 3'd4, 12'h002, 4'hF, 16'h3333, 16'h0, 1'b1, 1'b1, 2'd1}, // R1 squash
    '{4'd1, 2'd2, 3'd4, 12'h007, 4'hF, 16'hFFF0, 16'h0, 1'b1, 1'b1, 2'd1}  // R1 trap
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] policy = 2'd1;
  logic [2:0] thr_cnt = 3'd4;
  logic [11:0] status = '0;
  logic [3:0] active = 4'hF;
  logic [15:0] iq_cnt = '0, lsq_cnt = '0;
  logic grant = 1'b0;
  logic [1:0] sel_tid;
  logic sel_valid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_thread_sel i_fetch_thread_sel (
    .clk(clk), .rst_n(rst_n), .policy_i(policy), .thr_cnt_i(thr_cnt),
    .status_i(status), .active_i(active), .iq_cnt_i(iq_cnt),
    .lsq_cnt_i(lsq_cnt), .grant_i(grant), .sel_tid_o(sel_tid),
    .sel_valid_o(sel_valid)
  );

  task automatic check(input int req, input logic ev, input logic [1:0] et);
    checks++;
    if (sel_valid !== ev || sel_tid !== et) begin
      errors++;
      $display("FAIL R%0d: got valid=%0b tid=%0d expected valid=%0b tid=%0d",
               req, sel_valid, sel_tid, ev, et);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    // R4 reset order: thread 0 at head while reset is held
    #1 check(4, 1'b1, 2'd0);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      policy = TBL[i].pol; thr_cnt = TBL[i].cnt; status = TBL[i].st;
      active = TBL[i].act; iq_cnt = TBL[i].iq; lsq_cnt = TBL[i].lsq;
      grant = TBL[i].gnt;
      #1 check(int'(TBL[i].req), TBL[i].ev, TBL[i].et);
    end
    // R3 list is 2,1,3,0 before the mid-run reset
    @(negedge clk);
    policy = 2'd1; thr_cnt = 3'd4; status = '0; active = 4'hF; grant = 1'b0;
    #1 check(3, 1'b1, 2'd2);
    // R4 reset restores ascending order
    @(negedge clk) rst_n = 1'b0;
    #1 check(4, 1'b1, 2'd0);
    @(negedge clk) rst_n = 1'b1;
    #1 check(4, 1'b1, 2'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule